// File: doc/BRIEF.md
# PLL Frequency Change Sequencer

This block walks a clock synthesizer from one set of divider coefficients (reference divider M, feedback divider N, post divider PL) to another without putting a glitch or an overshoot on the clock it feeds. It drives the synthesizer's control pins directly and times every wait by counting a one-pulse-per-microsecond tick. Lock and ramp-done arrive from the analog side, and each passes through a two-flop synchronizer before the state machine uses it.

Five commands are accepted on a one-cycle `start_i` pulse. A slide ramps only N while the loop stays locked. A full reprogram moves the output through bypass and relocks it. A combined change picks the cheaper of the two and falls back to one plain reprogram if anything fails. Power-up and power-down complete the set. All command inputs are captured at the start pulse, so they only have to be valid in that cycle. `busy_o` stays high until `done_o` pulses, and `err_o` then reports the outcome.

Top module: `pll_seq`

## Requirements
- R1: After reset: `iddq_o`=1, `pll_en_o`=0, `vco_sel_o`=0 (bypass), `div2_o`=0 (1:1), `slowdown_o`=0, `ramp_en_o`=0, `lock_det_off_o`=1, `busy_o`=0, `err_o`=0, coefficients and step constants 0.
- R2: Power-up (`cmd_i`=3) clears `iddq_o` and then waits at least 5 ticks. It then loads the ramp steps from `ref_khz_i`: 12000, 12800 or 13000 give A=0x2B and B=0x0B; 19200 gives 0x12 and 0x08; 38400 gives 0x04 and 0x05. Any other value ends the command with `err_o`=2 and leaves the steps unchanged.
- R3: A slide (`cmd_i`=0) whose target equals the current N changes no output and ends with `err_o`=0.
- R4: A slide sets `slowdown_o`, waits one tick, writes N, waits one tick, sets `ramp_en_o`, and waits for synchronized ramp-done. It then drops both bits in the same cycle. `ramp_en_o` is high only while `slowdown_o` is high, and N changes while the PLL is enabled only under `slowdown_o`.
- R5: If ramp-done does not arrive within 500 ticks, the slide ends with `err_o`=1, and `slowdown_o` and `ramp_en_o` are both low.
- R6: A full reprogram (`cmd_i`=1) sets the 1:2 divider and waits 2 ticks. It then selects bypass, disables, writes M/N/PL, enables and clears lock-detect-off. After lock it selects the VCO, waits 2 ticks and restores 1:1. M and PL change only while the PLL is disabled, and the VCO is selected only while the PLL is enabled.
- R7: Every divider setting is written twice: each `div_wr_o` burst lasts exactly two cycles, so one reprogram gives four write pulses.
- R8: If lock is not reached within 300 ticks, the reprogram stops with `err_o`=1, the divider left at 1:2 and the output in bypass.
- R9: A combined change (`cmd_i`=2) on an enabled PLL whose M and PL are unchanged only slides N: no bypass and no re-enable.
- R10: Otherwise a combined change slides down to `n_lo_cur_i` (only if enabled), reprograms with the new M/PL and `n_lo_new_i`, then slides up to the new N. N therefore passes through those values in that order.
- R11: If any step of a combined change fails, one plain full reprogram to the new M/N/PL follows, and `err_o` reports its result.
- R12: Power-down (`cmd_i`=4) slides to `n_lo_cur_i` if enabled, then selects bypass, then disables, then sets `iddq_o`.
- R13: `busy_o` is high from the cycle after the start pulse until `done_o` pulses for one cycle as `busy_o` falls. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| cmd_i | input | 3 | 0 slide, 1 reprogram, 2 combined, 3 power-up, 4 power-down |
| new_m_i | input | MW | Target M |
| new_n_i | input | NW | Target N |
| new_pl_i | input | PW | Target PL |
| n_lo_cur_i | input | NW | Low N for the present M/PL |
| n_lo_new_i | input | NW | Low N for the target M/PL |
| ref_khz_i | input | RW | Reference frequency in kHz |
| lock_i | input | 1 | PLL lock, asynchronous |
| ramp_done_i | input | 1 | Ramp complete, asynchronous |
| tick_i | input | 1 | One pulse per microsecond |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished pulse |
| err_o | output | 2 | 0 ok, 1 timeout, 2 bad reference |
| coef_m_o | output | MW | M coefficient |
| coef_n_o | output | NW | N coefficient |
| coef_pl_o | output | PW | PL coefficient |
| slowdown_o | output | 1 | Slowdown mode |
| ramp_en_o | output | 1 | Dynamic ramp enable |
| pll_en_o | output | 1 | PLL enable |
| vco_sel_o | output | 1 | 1 VCO output, 0 bypass |
| div2_o | output | 1 | 1 output divider 1:2, 0 1:1 |
| div_wr_o | output | 1 | Divider write strobe |
| lock_det_off_o | output | 1 | Lock detector disabled |
| iddq_o | output | 1 | PLL power-down |
| step_a_o | output | SW | Ramp step A |
| step_b_o | output | SW | Ramp step B |

## Verification
A wrong state in the sequencer nearly always surfaces as an ordering error on the control pins in the very cycle it occurs. Examples are N moving outside slowdown, the VCO selected on a disabled PLL, or a single divider write strobe. Those pins are checked at every edge. Errors in phase bookkeeping inside a combined change show up only later, in the trace of N values and in the count of enable edges and bypass entries. The bench records both over each command and compares them at `done_o`. A timer that is off by a stage shows as a busy time that is too short, or a timeout code where success was due.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    CMD_SLIDE = 3'd0, CMD_PROG = 3'd1, CMD_COMBO = 3'd2, CMD_UP = 3'd3, CMD_DOWN = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_TIMEOUT = 2'd1, ERR_BADREF = 2'd2
  } err_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_UP_WAIT, ST_NEXT,
    ST_SL_CHK, ST_SL_W1, ST_SL_W2, ST_SL_RAMP,
    ST_PG_D2A, ST_PG_D2B, ST_PG_W1, ST_PG_OFF, ST_PG_WR, ST_PG_ON, ST_PG_ONW,
    ST_PG_LOCK, ST_PG_W2, ST_PG_D1A, ST_PG_D1B,
    ST_DN_BYP, ST_DN_DIS, ST_DN_PD, ST_FIN
  } state_e;
endpackage

// File: rtl/pll_seq_sync.sv
module pll_seq_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (start_i)              cnt_q <= val_i;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = !start_i && (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q == '0) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/pll_seq_steps.sv
module pll_seq_steps #(
  parameter int RW = 16,
  parameter int SW = 8
) (
  input  logic [RW-1:0] ref_khz_i,
  output logic [SW-1:0] step_a_o,
  output logic [SW-1:0] step_b_o,
  output logic          valid_o
);
  always_comb begin
    valid_o  = 1'b1;
    step_a_o = '0;
    step_b_o = '0;
    case (ref_khz_i)
      RW'(12000), RW'(12800), RW'(13000): begin step_a_o = SW'(8'h2B); step_b_o = SW'(8'h0B); end
      RW'(19200):                         begin step_a_o = SW'(8'h12); step_b_o = SW'(8'h08); end
      RW'(38400):                         begin step_a_o = SW'(8'h04); step_b_o = SW'(8'h05); end
      default:                            valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pll_seq.sv
module pll_seq
  import pll_seq_pkg::*;
#(
  parameter int MW         = 8,
  parameter int NW         = 8,
  parameter int PW         = 6,
  parameter int RW         = 16,
  parameter int SW         = 8,
  parameter int SETTLE_US  = 1,
  parameter int DIV_US     = 2,
  parameter int POWERUP_US = 5,
  parameter int RAMP_US    = 500,
  parameter int LOCK_US    = 300
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    cmd_i,
  input  logic [MW-1:0] new_m_i,
  input  logic [NW-1:0] new_n_i,
  input  logic [PW-1:0] new_pl_i,
  input  logic [NW-1:0] n_lo_cur_i,
  input  logic [NW-1:0] n_lo_new_i,
  input  logic [RW-1:0] ref_khz_i,
  input  logic          lock_i,
  input  logic          ramp_done_i,
  input  logic          tick_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    err_o,
  output logic [MW-1:0] coef_m_o,
  output logic [NW-1:0] coef_n_o,
  output logic [PW-1:0] coef_pl_o,
  output logic          slowdown_o,
  output logic          ramp_en_o,
  output logic          pll_en_o,
  output logic          vco_sel_o,
  output logic          div2_o,
  output logic          div_wr_o,
  output logic          lock_det_off_o,
  output logic          iddq_o,
  output logic [SW-1:0] step_a_o,
  output logic [SW-1:0] step_b_o
);
  localparam int TMAX0 = (RAMP_US > LOCK_US) ? RAMP_US : LOCK_US;
  localparam int TMAX  = (TMAX0 > POWERUP_US) ? TMAX0 : POWERUP_US;
  localparam int TW    = $clog2(TMAX + 1);

  state_e        state_q;
  cmd_e          op_q;
  logic [1:0]    ph_q;
  logic          sub_err_q;
  err_e          err_q;
  logic [MW-1:0] lat_m_q, coef_m_q;
  logic [NW-1:0] lat_n_q, nlo_cur_q, nlo_new_q, tgt_n_q, pg_n_q, coef_n_q;
  logic [PW-1:0] lat_pl_q, coef_pl_q;
  logic          busy_q, done_q, slow_q, ramp_q, en_q, vco_q, div2_q, dwr_q, ldo_q, iddq_q;
  logic [SW-1:0] step_a_q, step_b_q;
  logic          tmr_start_q, tmr_exp;
  logic [TW-1:0] tmr_val_q;
  logic [1:0]    stat_s;
  logic          lock_s, ramp_s, ref_ok, same_mp;
  logic [SW-1:0] lut_a, lut_b;

  pll_seq_sync #(.W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({lock_i, ramp_done_i}), .q_o(stat_s)
  );
  assign lock_s = stat_s[1];
  assign ramp_s = stat_s[0];

  pll_seq_timer #(.W(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .start_i(tmr_start_q), .val_i(tmr_val_q), .expired_o(tmr_exp)
  );

  pll_seq_steps #(.RW(RW), .SW(SW)) u_steps (
    .ref_khz_i(ref_khz_i), .step_a_o(lut_a), .step_b_o(lut_b), .valid_o(ref_ok)
  );

  assign same_mp = (lat_m_q == coef_m_q) && (lat_pl_q == coef_pl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;   op_q <= CMD_SLIDE;  ph_q <= '0;      sub_err_q <= 1'b0;
      err_q <= ERR_NONE;    lat_m_q <= '0;      lat_n_q <= '0;   lat_pl_q <= '0;
      nlo_cur_q <= '0;      nlo_new_q <= '0;    tgt_n_q <= '0;   pg_n_q <= '0;
      coef_m_q <= '0;       coef_n_q <= '0;     coef_pl_q <= '0;
      busy_q <= 1'b0;       done_q <= 1'b0;     slow_q <= 1'b0;  ramp_q <= 1'b0;
      en_q <= 1'b0;         vco_q <= 1'b0;      div2_q <= 1'b0;  dwr_q <= 1'b0;
      ldo_q <= 1'b1;        iddq_q <= 1'b1;     step_a_q <= '0;  step_b_q <= '0;
      tmr_start_q <= 1'b0;  tmr_val_q <= '0;
    end else begin
      done_q      <= 1'b0;
      dwr_q       <= 1'b0;
      tmr_start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i && cmd_i <= 3'd4) begin
          busy_q <= 1'b1;  err_q <= ERR_NONE;  op_q <= cmd_e'(cmd_i);
          ph_q <= '0;      sub_err_q <= 1'b0;
          lat_m_q <= new_m_i;  lat_n_q <= new_n_i;  lat_pl_q <= new_pl_i;
          nlo_cur_q <= n_lo_cur_i;  nlo_new_q <= n_lo_new_i;
          if (cmd_e'(cmd_i) == CMD_UP) begin
            iddq_q <= 1'b0;  tmr_start_q <= 1'b1;  tmr_val_q <= TW'(POWERUP_US);
            state_q <= ST_UP_WAIT;
          end else state_q <= ST_NEXT;
        end
        ST_UP_WAIT: if (tmr_exp) begin
          if (ref_ok) begin step_a_q <= lut_a; step_b_q <= lut_b; end
          else err_q <= ERR_BADREF;
          state_q <= ST_FIN;
        end
        // dispatcher: runs after every slide / reprogram returns
        ST_NEXT: unique case (op_q)
          CMD_SLIDE: if (ph_q == 0) begin ph_q <= 2'd1; tgt_n_q <= lat_n_q; state_q <= ST_SL_CHK; end
                     else state_q <= ST_FIN;
          CMD_PROG:  if (ph_q == 0) begin ph_q <= 2'd1; pg_n_q <= lat_n_q; state_q <= ST_PG_D2A; end
                     else state_q <= ST_FIN;
          CMD_COMBO: if (sub_err_q) begin
                       op_q <= CMD_PROG;  ph_q <= 2'd1;  err_q <= ERR_NONE;  sub_err_q <= 1'b0;
                       pg_n_q <= lat_n_q; state_q <= ST_PG_D2A;
                     end else unique case (ph_q)
                       2'd0: if (en_q && same_mp) begin
                               ph_q <= 2'd3; tgt_n_q <= lat_n_q; state_q <= ST_SL_CHK;
                             end else if (en_q) begin
                               ph_q <= 2'd1; tgt_n_q <= nlo_cur_q; state_q <= ST_SL_CHK;
                             end else begin
                               ph_q <= 2'd2; pg_n_q <= nlo_new_q; state_q <= ST_PG_D2A;
                             end
                       2'd1: begin ph_q <= 2'd2; pg_n_q <= nlo_new_q; state_q <= ST_PG_D2A; end
                       2'd2: begin ph_q <= 2'd3; tgt_n_q <= lat_n_q; state_q <= ST_SL_CHK; end
                       default: state_q <= ST_FIN;
                     endcase
          CMD_DOWN:  if (ph_q == 0) begin
                       ph_q <= 2'd1;
                       if (en_q) begin tgt_n_q <= nlo_cur_q; state_q <= ST_SL_CHK; end
                     end else state_q <= ST_DN_BYP;
          default:   state_q <= ST_FIN;
        endcase
        ST_SL_CHK: if (tgt_n_q == coef_n_q) state_q <= ST_NEXT;
                   else begin
                     slow_q <= 1'b1; tmr_start_q <= 1'b1; tmr_val_q <= TW'(SETTLE_US);
                     state_q <= ST_SL_W1;
                   end
        ST_SL_W1: if (tmr_exp) begin
          coef_n_q <= tgt_n_q; tmr_start_q <= 1'b1; tmr_val_q <= TW'(SETTLE_US); state_q <= ST_SL_W2;
        end
        ST_SL_W2: if (tmr_exp) begin
          ramp_q <= 1'b1; tmr_start_q <= 1'b1; tmr_val_q <= TW'(RAMP_US); state_q <= ST_SL_RAMP;
        end
        ST_SL_RAMP: if (ramp_s || tmr_exp) begin
          slow_q <= 1'b0;  ramp_q <= 1'b0;
          if (!ramp_s) begin sub_err_q <= 1'b1; err_q <= ERR_TIMEOUT; end
          state_q <= ST_NEXT;
        end
        ST_PG_D2A: begin div2_q <= 1'b1; dwr_q <= 1'b1; state_q <= ST_PG_D2B; end
        ST_PG_D2B: begin
          dwr_q <= 1'b1; tmr_start_q <= 1'b1; tmr_val_q <= TW'(DIV_US); state_q <= ST_PG_W1;
        end
        ST_PG_W1:  if (tmr_exp) begin vco_q <= 1'b0; state_q <= ST_PG_OFF; end
        ST_PG_OFF: begin en_q <= 1'b0; state_q <= ST_PG_WR; end
        ST_PG_WR:  begin
          coef_m_q <= lat_m_q; coef_n_q <= pg_n_q; coef_pl_q <= lat_pl_q; state_q <= ST_PG_ON;
        end
        ST_PG_ON:  begin
          en_q <= 1'b1; tmr_start_q <= 1'b1; tmr_val_q <= TW'(SETTLE_US); state_q <= ST_PG_ONW;
        end
        ST_PG_ONW: if (tmr_exp) begin
          ldo_q <= 1'b0; tmr_start_q <= 1'b1; tmr_val_q <= TW'(LOCK_US); state_q <= ST_PG_LOCK;
        end
        ST_PG_LOCK: if (lock_s) begin
          vco_q <= 1'b1; tmr_start_q <= 1'b1; tmr_val_q <= TW'(DIV_US); state_q <= ST_PG_W2;
        end else if (tmr_exp) begin
          sub_err_q <= 1'b1; err_q <= ERR_TIMEOUT; state_q <= ST_NEXT;
        end
        ST_PG_W2:  if (tmr_exp) state_q <= ST_PG_D1A;
        ST_PG_D1A: begin div2_q <= 1'b0; dwr_q <= 1'b1; state_q <= ST_PG_D1B; end
        ST_PG_D1B: begin dwr_q <= 1'b1; state_q <= ST_NEXT; end
        ST_DN_BYP: begin vco_q <= 1'b0; state_q <= ST_DN_DIS; end
        ST_DN_DIS: begin en_q <= 1'b0; state_q <= ST_DN_PD; end
        ST_DN_PD:  begin iddq_q <= 1'b1; state_q <= ST_FIN; end
        ST_FIN:    begin busy_q <= 1'b0; done_q <= 1'b1; state_q <= ST_IDLE; end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;           assign done_o = done_q;      assign err_o = err_q;
  assign coef_m_o = coef_m_q;       assign coef_n_o = coef_n_q;  assign coef_pl_o = coef_pl_q;
  assign slowdown_o = slow_q;       assign ramp_en_o = ramp_q;   assign pll_en_o = en_q;
  assign vco_sel_o = vco_q;         assign div2_o = div2_q;      assign div_wr_o = dwr_q;
  assign lock_det_off_o = ldo_q;    assign iddq_o = iddq_q;
  assign step_a_o = step_a_q;       assign step_b_o = step_b_q;

  AST_RAMP_IN_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_q |-> slow_q); // R4
  AST_SLOW_EXIT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slow_q) |-> !ramp_q); // R4
  AST_N_MOVE_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(coef_n_q) && en_q) |-> slow_q); // R4
  AST_MP_WHILE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({coef_m_q, coef_pl_q}) |-> !en_q); // R6
  AST_VCO_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_q |-> en_q); // R6
  AST_DIV_TWICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dwr_q) |=> dwr_q); // R7
  AST_PD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iddq_q |-> !en_q); // R12
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R13
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R13
endmodule

// File: tb/pll_seq_test.sv
`timescale 1ns/1ps
module pll_seq_test;
  localparam int TICK = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [7:0] new_m_i = '0, new_n_i = '0, n_lo_cur_i = '0, n_lo_new_i = '0;
  logic [5:0] new_pl_i = '0;
  logic [15:0] ref_khz_i = 16'd12000;
  logic lock_i = 1'b0, ramp_done_i = 1'b0, tick_i = 1'b0;
  logic busy_o, done_o, slowdown_o, ramp_en_o, pll_en_o, vco_sel_o, div2_o, div_wr_o;
  logic lock_det_off_o, iddq_o;
  logic [1:0] err_o;
  logic [7:0] coef_m_o, coef_n_o, step_a_o, step_b_o;
  logic [5:0] coef_pl_o;

  pll_seq uut (
    .clk_i, .rst_ni, .start_i, .cmd_i, .new_m_i, .new_n_i, .new_pl_i, .n_lo_cur_i,
    .n_lo_new_i, .ref_khz_i, .lock_i, .ramp_done_i, .tick_i, .busy_o, .done_o, .err_o,
    .coef_m_o, .coef_n_o, .coef_pl_o, .slowdown_o, .ramp_en_o, .pll_en_o, .vco_sel_o,
    .div2_o, .div_wr_o, .lock_det_off_o, .iddq_o, .step_a_o, .step_b_o
  );

  always #10 clk_i = ~clk_i;

  initial forever begin
    repeat (TICK - 1) @(negedge clk_i) tick_i = 1'b0;
    @(negedge clk_i) tick_i = 1'b1;
  end

  // analog model
  bit ramp_never = 0;
  int dead_attempt = -1;
  int en_total = 0;
  bit dead = 0, en_prv = 0;
  int lcnt = 0, rcnt = 0;
  always @(posedge clk_i) begin
    en_prv <= pll_en_o;
    if (pll_en_o && !en_prv) begin
      dead <= (en_total + 1 == dead_attempt);
      en_total <= en_total + 1;
    end
    if (!pll_en_o) begin lcnt <= 0; lock_i <= 1'b0; end
    else begin
      if (!lock_det_off_o && tick_i && lcnt < 3) lcnt <= lcnt + 1;
      lock_i <= (lcnt >= 3) && !dead;
    end
    if (!ramp_en_o || ramp_never) begin rcnt <= 0; ramp_done_i <= 1'b0; end
    else begin
      if (rcnt < 8) rcnt <= rcnt + 1;
      ramp_done_i <= (rcnt >= 8);
    end
  end

  int n_chk = 0, n_fail = 0;
  int viol, dwr, run, enr, byp, slr, gap, ntr_len;
  int ntr [8];
  logic [7:0] prv_n;
  logic prv_en, prv_vco, prv_slow;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    viol = 0; dwr = 0; run = 0; enr = 0; byp = 0; slr = 0; gap = 0; ntr_len = 0;
    prv_n = coef_n_o; prv_en = pll_en_o; prv_vco = vco_sel_o; prv_slow = slowdown_o;
  endtask

  task automatic step_mon(input bit in_op);
    @(negedge clk_i);
    if (coef_n_o != prv_n) begin
      if (ntr_len < 8) ntr[ntr_len] = int'(coef_n_o);
      ntr_len++;
      if (pll_en_o && !slowdown_o) viol++;
    end
    if (div_wr_o) run++;
    else begin
      if (run != 0 && run != 2) viol++;
      dwr += run; run = 0;
    end
    if (pll_en_o && !prv_en) enr++;
    if (!vco_sel_o && prv_vco) byp++;
    if (slowdown_o && !prv_slow) slr++;
    if (in_op && !busy_o && !done_o) gap++;
    prv_n = coef_n_o; prv_en = pll_en_o; prv_vco = vco_sel_o; prv_slow = slowdown_o;
  endtask

  task automatic run_cmd(input int cmd, input int m, input int n, input int pl,
                         input int nc, input int nn, output int cyc);
    mon_clear();
    cmd_i = 3'(cmd); new_m_i = 8'(m); new_n_i = 8'(n); new_pl_i = 6'(pl);
    n_lo_cur_i = 8'(nc); n_lo_new_i = 8'(nn); start_i = 1'b1;
    step_mon(0);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 20000) begin step_mon(1); cyc++; end
    chk(done_o, "R13", "command completes", cyc, 0);
    chk(gap == 0, "R13", "busy gaps", gap, 0);
  endtask

  task automatic t_reset();
    chk(iddq_o && !pll_en_o && !vco_sel_o && !div2_o, "R1", "power/enable/bypass/div", {iddq_o, pll_en_o, vco_sel_o, div2_o}, 8);
    chk(!slowdown_o && !ramp_en_o && lock_det_off_o, "R1", "slow/ramp/ldo", {slowdown_o, ramp_en_o, lock_det_off_o}, 1);
    chk(!busy_o && err_o == 0 && coef_n_o == 0 && step_a_o == 0, "R1", "busy/err/coef/step", {busy_o, err_o}, 0);
  endtask

  task automatic t_powerup(input int rkhz, input int ea, input int eb, input int eerr);
    int cyc;
    ref_khz_i = 16'(rkhz);
    run_cmd(3, 0, 0, 0, 0, 0, cyc);
    chk(!iddq_o, "R2", "power-down released", iddq_o, 0);
    chk(cyc >= 4 * TICK, "R2", "power-up wait cycles", cyc, 4 * TICK);
    chk(err_o == 2'(eerr), "R2", "ref error code", err_o, eerr);
    chk(step_a_o == 8'(ea) && step_b_o == 8'(eb), "R2", "step A", step_a_o, ea);
  endtask

  task automatic t_prog_basic();
    int cyc;
    run_cmd(1, 2, 50, 1, 0, 0, cyc);
    chk(err_o == 0, "R6", "err", err_o, 0);
    chk(coef_m_o == 2 && coef_n_o == 50 && coef_pl_o == 1, "R6", "coef N", coef_n_o, 50);
    chk(pll_en_o && vco_sel_o && !div2_o && !lock_det_off_o, "R6", "en/vco/div/ldo", {pll_en_o, vco_sel_o, div2_o, lock_det_off_o}, 12);
    chk(dwr == 4, "R7", "divider write pulses", dwr, 4);
    chk(viol == 0, "R7", "order violations", viol, 0);
  endtask

  task automatic t_slide();
    int cyc;
    run_cmd(0, 2, 80, 1, 0, 0, cyc);
    chk(coef_n_o == 80 && err_o == 0, "R4", "slide N", coef_n_o, 80);
    chk(slr == 1 && !slowdown_o && !ramp_en_o, "R4", "slowdown entries", slr, 1);
    chk(viol == 0 && enr == 0 && byp == 0, "R4", "no relock during slide", enr + byp + viol, 0);
    chk(cyc >= 2 * TICK, "R4", "slide settle cycles", cyc, 2 * TICK);
  endtask

  task automatic t_slide_same();
    int cyc;
    run_cmd(0, 2, 80, 1, 0, 0, cyc);
    chk(slr == 0 && ntr_len == 0 && err_o == 0, "R3", "equal slide no-op", slr + ntr_len, 0);
    chk(cyc < 10, "R3", "equal slide cycles", cyc, 10);
  endtask

  task automatic t_slide_timeout();
    int cyc;
    ramp_never = 1;
    run_cmd(0, 2, 90, 1, 0, 0, cyc);
    ramp_never = 0;
    chk(err_o == 1, "R5", "timeout code", err_o, 1);
    chk(!slowdown_o && !ramp_en_o, "R5", "bits cleared", {slowdown_o, ramp_en_o}, 0);
    chk(cyc >= 499 * TICK, "R5", "timeout wait cycles", cyc, 499 * TICK);
  endtask

  task automatic t_combo_same();
    int cyc;
    run_cmd(2, 2, 60, 1, 10, 10, cyc);
    chk(coef_n_o == 60 && err_o == 0, "R9", "combined N", coef_n_o, 60);
    chk(enr == 0 && byp == 0 && dwr == 0, "R9", "no reprogram", enr + byp + dwr, 0);
  endtask

  task automatic t_combo_diff();
    int cyc;
    run_cmd(2, 3, 70, 2, 30, 40, cyc);
    chk(err_o == 0 && coef_m_o == 3 && coef_pl_o == 2, "R10", "combined M", coef_m_o, 3);
    chk(ntr_len == 3, "R10", "N trace length", ntr_len, 3);
    chk(ntr[0] == 30 && ntr[1] == 40 && ntr[2] == 70, "R10", "N trace middle", ntr[1], 40);
    chk(enr == 1 && byp == 1 && dwr == 4, "R10", "one relock", enr, 1);
  endtask

  task automatic t_lock_timeout();
    int cyc;
    dead_attempt = en_total + 1;
    run_cmd(1, 4, 55, 1, 0, 0, cyc);
    chk(err_o == 1, "R8", "lock timeout code", err_o, 1);
    chk(div2_o && !vco_sel_o, "R8", "divider left 1:2 in bypass", {div2_o, vco_sel_o}, 2);
    chk(dwr == 2, "R8", "no restore writes", dwr, 2);
    chk(cyc >= 299 * TICK, "R8", "lock wait cycles", cyc, 299 * TICK);
  endtask

  task automatic t_combo_retry();
    int cyc;
    dead_attempt = en_total + 1;
    run_cmd(2, 2, 65, 1, 20, 25, cyc);
    chk(err_o == 0, "R11", "retry result", err_o, 0);
    chk(coef_n_o == 65 && coef_m_o == 2 && vco_sel_o && !div2_o, "R11", "final N", coef_n_o, 65);
    chk(enr == 2, "R11", "enable attempts", enr, 2);
    chk(ntr_len >= 3 && ntr[0] == 20 && ntr[1] == 25 && ntr[2] == 65, "R11", "N trace", ntr[2], 65);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    int low;
    mon_clear();
    cmd_i = 3'd1; new_m_i = 8'd5; new_n_i = 8'd45; new_pl_i = 6'd3; start_i = 1'b1;
    step_mon(0);
    start_i = 1'b0;
    repeat (6) step_mon(1);
    cmd_i = 3'd0; new_n_i = 8'd99; start_i = 1'b1;
    step_mon(1);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 20000) begin step_mon(1); cyc++; end
    chk(coef_n_o == 45 && coef_m_o == 5, "R13", "start while busy ignored", coef_n_o, 45);
    chk(gap == 0, "R13", "busy gaps", gap, 0);
    low = 0;
    for (int i = 0; i < 12; i++) begin step_mon(0); if (!busy_o) low++; end
    chk(low == 12 && coef_n_o == 45, "R13", "no queued command", low, 12);
  endtask

  task automatic t_powerdown();
    int cyc;
    run_cmd(4, 0, 0, 0, 22, 0, cyc);
    chk(ntr_len == 1 && coef_n_o == 22, "R12", "slide to low N", coef_n_o, 22);
    chk(iddq_o && !pll_en_o && !vco_sel_o, "R12", "powered down", {iddq_o, pll_en_o, vco_sel_o}, 4);
    chk(byp == 1 && err_o == 0, "R12", "bypass entries", byp, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_powerup(12000, 8'h2B, 8'h0B, 0);
    t_powerup(19200, 8'h12, 8'h08, 0);
    t_powerup(12800, 8'h2B, 8'h0B, 0);
    t_powerup(38400, 8'h04, 8'h05, 0);
    t_powerup(25000, 8'h04, 8'h05, 2);
    t_prog_basic();
    t_slide();
    t_slide_same();
    t_slide_timeout();
    t_combo_same();
    t_combo_diff();
    t_lock_timeout();
    t_combo_retry();
    t_busy_ignore();
    t_powerdown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule